// File: doc/BRIEF.md
# Indirect Register and Memory Access Window

This block gives a host on a narrow 32-bit little-endian bus indirect access to two larger spaces: a word-organised register space and a byte-addressed video memory. The host writes a target address into an index register and then reads or writes a 4-byte data window. Bit 31 of the index chooses the space. With bit 31 set, the window reaches memory at the address held in the low 31 index bits. With it clear, the window reaches the register at the index plus the byte offset of the access inside the window.

The register port carries only whole 32-bit words. Byte and halfword accesses to registers are therefore handled inside the block. A partial read pulls the addressed lanes out of the returned word. A partial write reads the word, merges the new lanes and writes it back. Memory accesses go out with their byte count and are dropped when they would run past the end of memory. Host addresses other than the index and the window reach the register space directly. Both downstream ports use a valid/ready handshake, and the host is told that an access has finished by a one-cycle done pulse that carries the read data.

Top module: `idx_window`

## Requirements
- R1: After reset the block is idle: host_ready is 1, reg_valid, mem_valid and host_done are 0, and the index register reads as 0.
- R2: The index register sits at host address IDX_ADDR and can be read and written as a full 32-bit value. A 1- or 2-byte write replaces only its low bytes, and a read of that size returns only its low bytes.
- R3: When index bit 31 is 1, an access to any of the four window addresses WIN_ADDR..WIN_ADDR+3 becomes a memory request at mem_addr = index[30:0], with the same size code. The byte offset inside the window plays no part. Write data and read data are right-aligned, with byte 0 in bits 7:0.
- R4: A memory access is issued only if index[30:0] is no greater than MEM_BYTES minus the access byte count. Otherwise a write produces no memory request and a read returns 0.
- R5: When index bit 31 is 0, a window access targets register byte address T = index + (host_addr − WIN_ADDR). The register port receives word address T[..:2], and T[1:0] is the lane offset.
- R6: Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. A register read of n bytes at lane offset o returns bits [8o+8n−1:8o] of the word in bits 8n−1:0, with zeros above.
- R7: A register write of n bytes at lane offset o changes only lanes o..o+n−1 of the word, and lanes above lane 3 are dropped. This is done as a word read followed by a word write. A 4-byte write at offset 0 is issued as a single word write with no read.
- R8: A window access whose register target is the index or window address is sent to the register port like any other register access. It is not redirected again, and the index register is left unchanged.
- R9: A register target at or above REG_BYTES reads as 0 and a write to it issues no request. A host address that is neither the index nor the window is used directly as a register byte address under the same rules.
- R10: A downstream request holds its valid, address, direction and data until ready. Read data is taken in the cycle after ready. At most one of reg_valid and mem_valid is high, host_ready is low while a request is in flight, and host_done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Block idle; a request is accepted on this edge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_size | input | 2 | Size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| host_wdata | input | 32 | Right-aligned write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done (0 for writes) |
| reg_valid | output | 1 | Register word request |
| reg_ready | input | 1 | Register port accepts the request |
| reg_we | output | 1 | Register write |
| reg_addr | output | REG_AW | Register word address |
| reg_wdata | output | 32 | Register write word |
| reg_rdata | input | 32 | Register read word, valid the cycle after ready |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 31 | Memory byte address |
| mem_size | output | 2 | Memory access size code |
| mem_wdata | output | 32 | Right-aligned memory write data |
| mem_rdata | input | 32 | Right-aligned memory read data, valid the cycle after ready |

## Verification
The bench builds the block with REG_BYTES = 64 and MEM_BYTES = 64 and leaves IDX_ADDR at 0 and WIN_ADDR at 4. With these sizes, one index write is enough to reach the last bytes of memory and the first unmapped register byte, so the exact boundary of the bounds check and the overflow by one access size can both be tested. Register words 0 and 1 are also reachable as ordinary targets of the window. The bench models the register port and the memory port with ready patterns that stall for a varying number of cycles, which exercises the hold-until-ready rule and the one-cycle data delay.

// File: rtl/idxw_pkg.sv
package idxw_pkg;

  typedef enum logic [1:0] {
    RT_NONE,
    RT_INDEX,
    RT_REG,
    RT_MEM
  } route_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RRD,
    S_RDAT,
    S_RWR,
    S_MREQ,
    S_MDAT
  } state_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] d, input logic [2:0] n);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      r[8*i +: 8] = (3'(i) < n) ? d[8*i +: 8] : 8'h00;
    end
    return r;
  endfunction

endpackage

// File: rtl/idxw_route.sv
module idxw_route
  import idxw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_ADDR  = 0,
  parameter int WIN_ADDR  = 4,
  parameter int REG_BYTES = 1024,
  parameter int MEM_BYTES = 1 << 20,
  parameter int REG_AW    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       index,
  output route_t            route,
  output logic [REG_AW-1:0] word,
  output logic [1:0]        off,
  output logic [30:0]       maddr
);

  localparam logic [ADDR_W-1:0] IDX_A   = ADDR_W'(IDX_ADDR);
  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(WIN_ADDR);
  localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(WIN_ADDR + 3);
  localparam logic [32:0]       MEM_LIM = 33'(MEM_BYTES);
  localparam logic [31:0]       REG_LIM = 32'(REG_BYTES);

  logic        win_hit;
  logic [1:0]  win_off;
  logic [31:0] sel;
  logic [32:0] mem_end;

  always_comb begin
    win_hit = (addr >= WIN_LO) && (addr <= WIN_HI);
    win_off = 2'(addr - WIN_LO);
    if (win_hit) begin
      sel = {1'b0, index[30:0]} + {30'd0, win_off};
    end else begin
      sel = 32'(addr);
    end
    mem_end = {2'b00, index[30:0]} + {30'd0, size_bytes(size)};

    if (addr == IDX_A) begin
      route = RT_INDEX;
    end else if (win_hit && index[31]) begin
      route = (mem_end <= MEM_LIM) ? RT_MEM : RT_NONE;
    end else begin
      route = (sel < REG_LIM) ? RT_REG : RT_NONE;
    end

    word  = sel[REG_AW+1:2];
    off   = sel[1:0];
    maddr = index[30:0];
  end

endmodule

// File: rtl/idxw_lanes.sv
module idxw_lanes #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] old_word,
  input  logic [8*LANES-1:0] wdata,
  input  logic [1:0]         off,
  input  logic [2:0]         nbytes,
  output logic [8*LANES-1:0] merged,
  output logic [8*LANES-1:0] extracted
);

  localparam int W  = 8 * LANES;
  localparam int MW = 2 * LANES;

  logic [MW-1:0] span;
  logic [W-1:0]  up;
  logic [W-1:0]  down;

  always_comb begin
    span = ((MW'(1) << nbytes) - MW'(1)) << off;
    up   = wdata << {off, 3'b000};
    down = old_word >> {off, 3'b000};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8]    = span[i] ? up[8*i +: 8] : old_word[8*i +: 8];
    assign extracted[8*i +: 8] = (3'(i) < nbytes) ? down[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/idx_window.sv
module idx_window
  import idxw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_ADDR  = 0,
  parameter int WIN_ADDR  = 4,
  parameter int REG_BYTES = 1024,
  parameter int MEM_BYTES = 1 << 20,
  parameter int REG_AW    = $clog2(REG_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_done,
  output logic [31:0]       host_rdata,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [30:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  state_t            state;
  logic [31:0]       index_q;
  logic              we_q;
  logic [31:0]       wdata_q;
  logic [31:0]       wbuf_q;
  logic [2:0]        n_q;
  logic [1:0]        off_q;
  logic [1:0]        size_q;
  logic [REG_AW-1:0] word_q;
  logic [30:0]       maddr_q;
  logic              done_q;
  logic [31:0]       rdata_q;

  route_t            rt;
  logic [REG_AW-1:0] rt_word;
  logic [1:0]        rt_off;
  logic [30:0]       rt_maddr;
  logic [2:0]        host_n;
  logic              full_word;

  logic [31:0]       idx_merged;
  logic [31:0]       idx_extract;
  logic [31:0]       rg_merged;
  logic [31:0]       rg_extract;

  idxw_route #(
    .ADDR_W   (ADDR_W),
    .IDX_ADDR (IDX_ADDR),
    .WIN_ADDR (WIN_ADDR),
    .REG_BYTES(REG_BYTES),
    .MEM_BYTES(MEM_BYTES),
    .REG_AW   (REG_AW)
  ) u_route (
    .addr (host_addr),
    .size (host_size),
    .index(index_q),
    .route(rt),
    .word (rt_word),
    .off  (rt_off),
    .maddr(rt_maddr)
  );

  // Index register lanes: always offset 0
  idxw_lanes #(.LANES(4)) u_idx_lanes (
    .old_word (index_q),
    .wdata    (host_wdata),
    .off      (2'd0),
    .nbytes   (host_n),
    .merged   (idx_merged),
    .extracted(idx_extract)
  );

  // Register word lanes: operate on the word returned by the register port
  idxw_lanes #(.LANES(4)) u_reg_lanes (
    .old_word (reg_rdata),
    .wdata    (wdata_q),
    .off      (off_q),
    .nbytes   (n_q),
    .merged   (rg_merged),
    .extracted(rg_extract)
  );

  assign host_n    = size_bytes(host_size);
  assign full_word = (host_n == 3'd4) && (rt_off == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      index_q <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      wbuf_q  <= '0;
      n_q     <= 3'd1;
      off_q   <= '0;
      size_q  <= '0;
      word_q  <= '0;
      maddr_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (host_valid) begin
            we_q    <= host_we;
            wdata_q <= host_wdata;
            wbuf_q  <= host_wdata;
            n_q     <= host_n;
            off_q   <= rt_off;
            size_q  <= host_size;
            word_q  <= rt_word;
            maddr_q <= rt_maddr;
            case (rt)
              RT_INDEX: begin
                if (host_we) index_q <= idx_merged;
                rdata_q <= host_we ? 32'd0 : idx_extract;
                done_q  <= 1'b1;
              end
              RT_REG: begin
                state <= (host_we && full_word) ? S_RWR : S_RRD;
              end
              RT_MEM: begin
                state <= S_MREQ;
              end
              default: begin
                rdata_q <= 32'd0;
                done_q  <= 1'b1;
              end
            endcase
          end
        end
        S_RRD: begin
          if (reg_ready) state <= S_RDAT;
        end
        S_RDAT: begin
          if (we_q) begin
            wbuf_q <= rg_merged;
            state  <= S_RWR;
          end else begin
            rdata_q <= rg_extract;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_RWR: begin
          if (reg_ready) begin
            rdata_q <= 32'd0;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_MREQ: begin
          if (mem_ready) begin
            if (we_q) begin
              rdata_q <= 32'd0;
              done_q  <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_MDAT;
            end
          end
        end
        S_MDAT: begin
          rdata_q <= keep_low(mem_rdata, n_q);
          done_q  <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign host_ready = (state == S_IDLE);
  assign host_done  = done_q;
  assign host_rdata = rdata_q;

  assign reg_valid  = (state == S_RRD) || (state == S_RWR);
  assign reg_we     = (state == S_RWR);
  assign reg_addr   = word_q;
  assign reg_wdata  = wbuf_q;

  assign mem_valid  = (state == S_MREQ);
  assign mem_we     = we_q;
  assign mem_addr   = maddr_q;
  assign mem_size   = size_q;
  assign mem_wdata  = keep_low(wdata_q, n_q);

endmodule

// File: rtl/idx_window_chk.sv
module idx_window_chk
  import idxw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_ADDR  = 0,
  parameter int WIN_ADDR  = 4,
  parameter int REG_BYTES = 1024,
  parameter int MEM_BYTES = 1 << 20,
  parameter int REG_AW    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_done,
  input logic [31:0]       host_rdata,
  input logic              reg_valid,
  input logic              reg_ready,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [30:0]       mem_addr,
  input logic [1:0]        mem_size,
  input logic [31:0]       mem_wdata
);

  logic direct_unmapped;
  assign direct_unmapped = (32'(host_addr) >= 32'(REG_BYTES)) &&
                           (host_addr != ADDR_W'(IDX_ADDR)) &&
                           ((host_addr < ADDR_W'(WIN_ADDR)) || (host_addr > ADDR_W'(WIN_ADDR + 3)));

  // R4: a memory request never runs past the end of memory
  p_mem_in_bounds_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (({2'b00, mem_addr} + {30'd0, size_bytes(mem_size)}) <= 33'(MEM_BYTES)));

  // R9: a direct read of an unmapped address completes next cycle with zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready && !host_we && direct_unmapped) |=> (host_done && host_rdata == 32'd0));

  // R10: register request held until accepted
  p_reg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

  // R10: memory request held until accepted
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: never both downstream ports at once
  p_one_port_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_valid, mem_valid}));

  // R10: host is not accepted while a request is outstanding
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_valid || mem_valid) |-> !host_ready);

  // R7: an accepted register write completes the access on the next cycle
  p_wr_done_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_we && reg_ready) |=> host_done);

  // R10: register read data is taken a cycle after ready, so no completion yet
  p_rd_delay_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_we && reg_ready) |=> !host_done);

endmodule

bind idx_window idx_window_chk #(
  .ADDR_W   (ADDR_W),
  .IDX_ADDR (IDX_ADDR),
  .WIN_ADDR (WIN_ADDR),
  .REG_BYTES(REG_BYTES),
  .MEM_BYTES(MEM_BYTES),
  .REG_AW   (REG_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_valid(host_valid),
  .host_ready(host_ready),
  .host_we   (host_we),
  .host_addr (host_addr),
  .host_done (host_done),
  .host_rdata(host_rdata),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata)
);

// File: tb/idx_window_tb_top.sv
`timescale 1ns/1ps
module idx_window_tb_top;

  localparam int ADDR_W = 16;
  localparam int RB     = 64;
  localparam int MB     = 64;
  localparam int RAW    = $clog2(RB / 4);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_valid = 1'b0;
  logic              host_ready;
  logic              host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [1:0]        host_size = '0;
  logic [31:0]       host_wdata = '0;
  logic              host_done;
  logic [31:0]       host_rdata;
  logic              reg_valid;
  logic              reg_ready;
  logic              reg_we;
  logic [RAW-1:0]    reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              mem_valid;
  logic              mem_ready;
  logic              mem_we;
  logic [30:0]       mem_addr;
  logic [1:0]        mem_size;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata;

  always #10 clk = ~clk;  // 50 MHz

  idx_window #(
    .ADDR_W   (ADDR_W),
    .IDX_ADDR (0),
    .WIN_ADDR (4),
    .REG_BYTES(RB),
    .MEM_BYTES(MB)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .host_valid(host_valid),
    .host_ready(host_ready),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_size (host_size),
    .host_wdata(host_wdata),
    .host_done (host_done),
    .host_rdata(host_rdata),
    .reg_valid (reg_valid),
    .reg_ready (reg_ready),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // Target models with stalling ready patterns
  logic [31:0] rf [RB/4];
  logic [7:0]  mb [MB];
  logic [3:0]  cyc;
  int          reg_rd_cnt, reg_wr_cnt, mem_wr_cnt;

  assign reg_ready = (cyc[1:0] != 2'd0);
  assign mem_ready = cyc[0];

  always @(posedge clk) begin
    if (rst) begin
      cyc        <= '0;
      reg_rdata  <= '0;
      mem_rdata  <= '0;
      reg_rd_cnt <= 0;
      reg_wr_cnt <= 0;
      mem_wr_cnt <= 0;
      for (int i = 0; i < RB/4; i++) rf[i] <= '0;
      for (int i = 0; i < MB; i++) mb[i] <= '0;
    end else begin
      cyc <= cyc + 4'd1;
      if (reg_valid && reg_ready) begin
        if (reg_we) begin
          rf[reg_addr] <= reg_wdata;
          reg_wr_cnt   <= reg_wr_cnt + 1;
        end else begin
          reg_rdata  <= rf[reg_addr];
          reg_rd_cnt <= reg_rd_cnt + 1;
        end
      end
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++) begin
            if (k < ((mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4))
              mb[(int'(mem_addr[5:0]) + k) % MB] <= mem_wdata[8*k +: 8];
          end
          mem_wr_cnt <= mem_wr_cnt + 1;
        end else begin
          for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] <= mb[(int'(mem_addr[5:0]) + k) % MB];
        end
      end
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int w;
    @(negedge clk);
    host_valid = 1'b1;
    host_we    = we;
    host_addr  = a;
    host_size  = sz;
    host_wdata = wd;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    w = 0;
    while (!host_done && w < 500) begin
      @(negedge clk);
      w++;
    end
    if (!host_done) begin
      n_err++;
      $display("FAIL R10 access timeout actual=0 expected=1");
      rd = 32'hXXXX_XXXX;
    end else begin
      rd = host_rdata;
    end
  endtask

  // Vector table: write enable, host address, size code, write data, expected read data
  localparam int N = 28;
  localparam logic        T_WE [N] = '{1,1,0,0,0,1,0,1,0,0,1,1,0,0,1,1,0,0,1,0,1,0,1,1,0,0,0,0};
  localparam logic [15:0] T_AD [N] = '{16'h0, 16'h4, 16'h4, 16'h5, 16'h6, 16'h7, 16'h4, 16'h6,
                                       16'h10, 16'h0, 16'h0, 16'h4, 16'h7, 16'h4, 16'h0, 16'h4,
                                       16'h4, 16'h4, 16'h0, 16'h4, 16'h0, 16'h0, 16'h0, 16'h4,
                                       16'h0, 16'h4, 16'h40, 16'h11};
  localparam logic [1:0]  T_SZ [N] = '{2,2,2,0,1,0,2,2,2,2,2,2,1,0,2,1,1,2,2,3,0,2,2,2,2,2,2,0};
  localparam logic [31:0] T_WD [N] = '{32'h10, 32'hDEADBEEF, 0, 0, 0, 32'h11, 0, 32'hAABBCCDD,
                                       0, 0, 32'h80000020, 32'h04030201, 0, 0, 32'h8000003E, 32'hBBAA,
                                       0, 0, 32'h8000003C, 0, 32'h77, 0, 0, 32'hCAFEF00D,
                                       0, 0, 0, 0};
  localparam logic [31:0] T_EX [N] = '{0, 0, 32'hDEADBEEF, 32'hBE, 32'hDEAD, 0, 32'h11ADBEEF, 0,
                                       32'hCCDDBEEF, 32'h10, 0, 0, 32'h0201, 32'h01, 0, 0,
                                       32'hBBAA, 0, 0, 32'hBBAA0000, 0, 32'h80000077, 0, 0,
                                       0, 32'hCAFEF00D, 0, 32'hBE};
  // Rows: 0 R2 index write | 1-2 R5 full register | 3-4 R6 extract | 5-7 R7 merge/truncate
  // 8 R9 direct | 9 R2 | 10-12 R3 memory, offset ignored | 13 R6 | 14-19 R4 bounds
  // 20-21 R2 partial index | 22-25 R8 no recursion | 26 R9 unmapped | 27 R6 direct byte
  localparam int T_RQ [N] = '{2,5,5,6,6,7,7,7,9,2,3,3,3,6,4,4,4,4,4,4,2,2,8,8,8,8,9,6};

  initial begin
    logic [31:0] rd;
    int c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check(1, {28'd0, host_ready, reg_valid, mem_valid, host_done}, 32'b1000);
    access(1'b0, 16'h0, 2'd2, 32'h0, rd);
    check(1, rd, 32'h0);  // R1 index resets to zero

    for (int i = 0; i < N; i++) begin
      access(T_WE[i], T_AD[i], T_SZ[i], T_WD[i], rd);
      check(T_RQ[i], rd, T_EX[i]);
    end

    // R7: full aligned write skips the read; partial write reads once
    access(1'b1, 16'h0, 2'd2, 32'h10, rd);
    c0 = reg_rd_cnt;
    access(1'b1, 16'h4, 2'd2, 32'h01020304, rd);
    check(7, 32'(reg_rd_cnt - c0), 32'd0);
    access(1'b1, 16'h5, 2'd0, 32'hFF, rd);
    check(7, 32'(reg_rd_cnt - c0), 32'd1);
    access(1'b0, 16'h4, 2'd2, 32'h0, rd);
    check(7, rd, 32'h0102FF04);

    // R4: overflowing memory write issues no request and leaves memory intact
    access(1'b1, 16'h0, 2'd2, 32'h8000003E, rd);
    c0 = mem_wr_cnt;
    access(1'b1, 16'h4, 2'd2, 32'h12345678, rd);
    check(4, 32'(mem_wr_cnt - c0), 32'd0);
    access(1'b0, 16'h4, 2'd1, 32'h0, rd);
    check(4, rd, 32'hBBAA);

    // R9: unmapped register target, no request either way
    access(1'b1, 16'h0, 2'd2, 32'h40, rd);
    c0 = reg_rd_cnt + reg_wr_cnt;
    access(1'b1, 16'h4, 2'd2, 32'h55, rd);
    check(9, 32'(reg_rd_cnt + reg_wr_cnt - c0), 32'd0);
    access(1'b0, 16'h4, 2'd2, 32'h0, rd);
    check(9, rd, 32'h0);
    check(9, 32'(reg_rd_cnt + reg_wr_cnt - c0), 32'd0);

    // R10: completion is a single-cycle pulse
    access(1'b0, 16'h0, 2'd2, 32'h0, rd);
    check(2, rd, 32'h40);
    @(negedge clk);
    check(10, {31'd0, host_done}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule